// File: doc/BRIEF.md
# Tagged Auto-Incrementing Memory Fill Window

This block sits between a host register bus and the two local memories of a small embedded processor: an instruction store and a data store. The host loads firmware by pointing one of several independent access ports at a byte offset and then streaming 32-bit words into that port's data register. Each port can advance its own pointer after every data write, so a whole image goes in as one control write followed by a run of data writes.

The instruction store is divided into 256-byte blocks. Each block records a 16-bit tag and a secure attribute, taken from the writing port at the moment of each write. Every word in either store also carries a written flag, and every instruction word carries the secure mode it was written in. A lookup port on each store lets the processor side, or a test, see a word together with these attributes. Host reads return registered data one cycle after the address is presented.

Top module: `tagged_mem_window`

## Requirements
- R1: Instruction ports occupy window bytes `16*p` (control), `16*p+4` (data) and `16*p+8` (tag) for p in 0..3. Data ports occupy `64+8*q` (control) and `64+8*q+4` (data) for q in 0..7. Address bits 1:0 are ignored.
- R2: A control register holds the offset in bits 15:0 and an auto-step flag in bit 24. On instruction ports only, bit 28 holds a secure flag. Offset bits 1:0 always read 0, data ports read bit 28 as 0, and all fields reset to 0.
- R3: A data-register write stores the word at word index `offset>>2` modulo the store depth. The lookup ports apply the same modulo to their byte address.
- R4: After a data write with the auto-step flag set, the port's offset grows by 4 and wraps at 16 bits. With the flag clear, the offset is unchanged.
- R5: Reading a data register returns the word at the port's current offset and leaves the offset unchanged. All host reads return `bus_rdata` on the clock edge after the address is presented.
- R6: The tag register of an instruction port holds bits 15:0 of the written value and reads back zero-extended.
- R7: An instruction write copies the port's tag and secure flag into the attributes of block `(offset>>8)` modulo the block count. The most recent write wins.
- R8: Each word has a written flag, cleared by reset and set by a data write. Each instruction word also records the secure flag of its most recent writer.
- R9: Ports share the stores but keep separate offset, flags and tag. A write to one port changes no other port's registers.
- R10: Addresses outside the mapped registers read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Window byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| imem_look_addr | input | 16 | Instruction lookup byte address |
| imem_look_data | output | 32 | Instruction word at lookup address |
| imem_look_valid | output | 1 | Word has been written |
| imem_look_secure | output | 1 | Word was written in secure mode |
| imem_look_tag | output | 16 | Tag of the word's block |
| imem_look_blk_secure | output | 1 | Secure attribute of the word's block |
| dmem_look_addr | input | 16 | Data lookup byte address |
| dmem_look_data | output | 32 | Data word at lookup address |
| dmem_look_valid | output | 1 | Word has been written |

## Verification
The bench uses the default parameters: four instruction ports, eight data ports, and 256 words in each store, which gives four instruction blocks. With stores this small, the 16-bit offset wrap and the store-depth aliasing can both be reached. An offset of 0xFFFC lands on the last word and then steps to zero, and lookup address 0x7FC aliases 0x3FC. Blocks 1 and 3 are written from ports with different tags and secure settings, so the most-recent-writer rule for block attributes is observed.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    typedef enum logic [1:0] {
        REG_CTRL,
        REG_DATA,
        REG_TAG,
        REG_NONE
    } reg_kind_e;

    localparam int OFFS_W      = 16;
    localparam int TAG_W       = 16;
    localparam int AINC_BIT    = 24;
    localparam int SEC_BIT     = 28;
    localparam int BLOCK_SHIFT = 8;
    localparam int WORD_BYTES  = 4;
    localparam int IPORT_SPAN  = 16;
    localparam int DPORT_SPAN  = 8;
endpackage

// File: rtl/memwin_port.sv
module memwin_port
    import memwin_pkg::*;
#(
    parameter bit HAS_SEC_TAG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              data_wr,
    input  logic              tag_wr,
    input  logic [31:0]       wdata,
    output logic [OFFS_W-1:0] offs,
    output logic              ainc,
    output logic              secure,
    output logic [TAG_W-1:0]  tag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs <= '0;
            ainc <= 1'b0;
        end else if (ctrl_wr) begin
            offs <= {wdata[OFFS_W-1:2], 2'b00};
            ainc <= wdata[AINC_BIT];
        end else if (data_wr && ainc) begin
            offs <= offs + OFFS_W'(WORD_BYTES);
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{wdata[31:29], wdata[27:25], wdata[23:16], wdata[1:0]};

    generate
        if (HAS_SEC_TAG) begin : g_sec
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    secure <= 1'b0;
                    tag    <= '0;
                end else begin
                    if (ctrl_wr) secure <= wdata[SEC_BIT];
                    if (tag_wr)  tag    <= wdata[TAG_W-1:0];
                end
            end
        end else begin : g_nosec
            assign secure = 1'b0;
            assign tag    = '0;
            logic unused_sec;
            assign unused_sec = ^{tag_wr, wdata[SEC_BIT]};
        end
    endgenerate

    AST_AINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !ctrl_wr && ainc) |=> (offs == $past(offs) + 16'd4)); // R4
    AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_wr && !(data_wr && ainc)) |=> $stable(offs)); // R4
endmodule

// File: rtl/memwin_store.sv
module memwin_store
    import memwin_pkg::*;
#(
    parameter int WORDS   = 256,
    parameter bit HAS_BLK = 1'b1,
    localparam int IDXW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  acc_idx,
    input  logic [31:0]      wr_data,
    input  logic             wr_sec,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [31:0]      acc_data,
    input  logic [IDXW-1:0]  look_idx,
    output logic [31:0]      look_data,
    output logic             look_valid,
    output logic             look_sec,
    output logic [TAG_W-1:0] look_tag,
    output logic             look_blk_sec
);
    localparam int BLKW   = IDXW - (BLOCK_SHIFT - 2);
    localparam int BLOCKS = 1 << BLKW;

    logic [31:0]      mem [WORDS];
    logic [WORDS-1:0] written_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[acc_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     written_q <= '0;
        else if (wr_en) written_q[acc_idx] <= 1'b1;
    end

    assign acc_data   = mem[acc_idx];
    assign look_data  = mem[look_idx];
    assign look_valid = written_q[look_idx];

    generate
        if (HAS_BLK) begin : g_blk
            logic [WORDS-1:0]  wsec_q;
            logic [TAG_W-1:0]  blk_tag_q [BLOCKS];
            logic [BLOCKS-1:0] blk_sec_q;
            logic [BLKW-1:0]   wr_blk;
            logic [BLKW-1:0]   look_blk;

            assign wr_blk   = acc_idx[IDXW-1 -: BLKW];
            assign look_blk = look_idx[IDXW-1 -: BLKW];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    wsec_q    <= '0;
                    blk_sec_q <= '0;
                    for (int b = 0; b < BLOCKS; b++) blk_tag_q[b] <= '0;
                end else if (wr_en) begin
                    wsec_q[acc_idx]   <= wr_sec;
                    blk_sec_q[wr_blk] <= wr_sec;
                    blk_tag_q[wr_blk] <= wr_tag;
                end
            end

            assign look_sec     = wsec_q[look_idx];
            assign look_tag     = blk_tag_q[look_blk];
            assign look_blk_sec = blk_sec_q[look_blk];

            AST_BLK_TAG: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (blk_tag_q[$past(wr_blk)] == $past(wr_tag))); // R7
            AST_BLK_SEC: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en |=> (blk_sec_q[$past(wr_blk)] == $past(wr_sec))); // R7
        end else begin : g_noblk
            assign look_sec     = 1'b0;
            assign look_tag     = '0;
            assign look_blk_sec = 1'b0;
            logic unused_attr;
            assign unused_attr = ^{wr_sec, wr_tag};
        end
    endgenerate

    AST_WRITTEN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((written_q & $past(written_q)) == $past(written_q))); // R8
    AST_WR_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> written_q[$past(acc_idx)]); // R8
endmodule

// File: rtl/tagged_mem_window.sv
module tagged_mem_window
    import memwin_pkg::*;
#(
    parameter int AW          = 8,
    parameter int IMEM_PORTS  = 4,
    parameter int DMEM_PORTS  = 8,
    parameter int IMEM_WORDS  = 256,
    parameter int DMEM_WORDS  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       imem_look_addr,
    output logic [31:0]       imem_look_data,
    output logic              imem_look_valid,
    output logic              imem_look_secure,
    output logic [15:0]       imem_look_tag,
    output logic              imem_look_blk_secure,
    input  logic [15:0]       dmem_look_addr,
    output logic [31:0]       dmem_look_data,
    output logic              dmem_look_valid
);
    localparam int IPW    = (IMEM_PORTS > 1) ? $clog2(IMEM_PORTS) : 1;
    localparam int DPW    = (DMEM_PORTS > 1) ? $clog2(DMEM_PORTS) : 1;
    localparam int IIW    = $clog2(IMEM_WORDS);
    localparam int DIW    = $clog2(DMEM_WORDS);
    localparam int IBYTES = IMEM_PORTS * IPORT_SPAN;
    localparam int DBASE  = IBYTES;
    localparam int DBYTES = DMEM_PORTS * DPORT_SPAN;

    // ---------------- address decode ----------------
    logic [31:0]  addr_ext;
    logic [31:0]  d_rel;
    logic         hit_i, hit_d;
    logic [IPW-1:0] ip_idx;
    logic [DPW-1:0] dp_idx;
    reg_kind_e    ikind, dkind;

    assign addr_ext = 32'(bus_addr);
    assign d_rel    = addr_ext - 32'(DBASE);

    always_comb begin
        hit_i  = (addr_ext < 32'(IBYTES));
        hit_d  = !hit_i && (d_rel < 32'(DBYTES));
        ip_idx = IPW'(addr_ext >> 4);
        dp_idx = DPW'(d_rel >> 3);
        unique case (bus_addr[3:2])
            2'd0:    ikind = REG_CTRL;
            2'd1:    ikind = REG_DATA;
            2'd2:    ikind = REG_TAG;
            default: ikind = REG_NONE;
        endcase
        dkind = d_rel[2] ? REG_DATA : REG_CTRL;
    end

    // ---------------- port register sets ----------------
    logic [IMEM_PORTS-1:0]             i_ctrl_wr, i_data_wr, i_tag_wr, i_ainc, i_sec;
    logic [IMEM_PORTS-1:0][OFFS_W-1:0] i_offs;
    logic [IMEM_PORTS-1:0][TAG_W-1:0]  i_tag;
    logic [DMEM_PORTS-1:0]             d_ctrl_wr, d_data_wr, d_ainc, d_sec;
    logic [DMEM_PORTS-1:0][OFFS_W-1:0] d_offs;
    logic [DMEM_PORTS-1:0][TAG_W-1:0]  d_tag;

    generate
        for (genvar p = 0; p < IMEM_PORTS; p++) begin : g_iport
            logic sel;
            assign sel          = bus_we && hit_i && (ip_idx == IPW'(p));
            assign i_ctrl_wr[p] = sel && (ikind == REG_CTRL);
            assign i_data_wr[p] = sel && (ikind == REG_DATA);
            assign i_tag_wr[p]  = sel && (ikind == REG_TAG);
            memwin_port #(.HAS_SEC_TAG(1'b1)) u_port (
                .clk(clk), .rst_n(rst_n),
                .ctrl_wr(i_ctrl_wr[p]), .data_wr(i_data_wr[p]), .tag_wr(i_tag_wr[p]),
                .wdata(bus_wdata),
                .offs(i_offs[p]), .ainc(i_ainc[p]), .secure(i_sec[p]), .tag(i_tag[p])
            );
        end
        for (genvar q = 0; q < DMEM_PORTS; q++) begin : g_dport
            logic sel;
            assign sel          = bus_we && hit_d && (dp_idx == DPW'(q));
            assign d_ctrl_wr[q] = sel && (dkind == REG_CTRL);
            assign d_data_wr[q] = sel && (dkind == REG_DATA);
            memwin_port #(.HAS_SEC_TAG(1'b0)) u_port (
                .clk(clk), .rst_n(rst_n),
                .ctrl_wr(d_ctrl_wr[q]), .data_wr(d_data_wr[q]), .tag_wr(1'b0),
                .wdata(bus_wdata),
                .offs(d_offs[q]), .ainc(d_ainc[q]), .secure(d_sec[q]), .tag(d_tag[q])
            );
        end
    endgenerate

    // ---------------- shared stores ----------------
    logic [IIW-1:0] i_acc_idx;
    logic [DIW-1:0] d_acc_idx;
    logic [31:0]    i_acc_data, d_acc_data;
    logic [TAG_W-1:0] d_look_tag_nc;
    logic           d_look_sec_nc, d_look_bsec_nc;

    assign i_acc_idx = i_offs[ip_idx][2 +: IIW];
    assign d_acc_idx = d_offs[dp_idx][2 +: DIW];

    memwin_store #(.WORDS(IMEM_WORDS), .HAS_BLK(1'b1)) u_istore (
        .clk(clk), .rst_n(rst_n),
        .wr_en(|i_data_wr), .acc_idx(i_acc_idx), .wr_data(bus_wdata),
        .wr_sec(i_sec[ip_idx]), .wr_tag(i_tag[ip_idx]),
        .acc_data(i_acc_data),
        .look_idx(imem_look_addr[2 +: IIW]),
        .look_data(imem_look_data), .look_valid(imem_look_valid),
        .look_sec(imem_look_secure), .look_tag(imem_look_tag),
        .look_blk_sec(imem_look_blk_secure)
    );

    memwin_store #(.WORDS(DMEM_WORDS), .HAS_BLK(1'b0)) u_dstore (
        .clk(clk), .rst_n(rst_n),
        .wr_en(|d_data_wr), .acc_idx(d_acc_idx), .wr_data(bus_wdata),
        .wr_sec(1'b0), .wr_tag('0),
        .acc_data(d_acc_data),
        .look_idx(dmem_look_addr[2 +: DIW]),
        .look_data(dmem_look_data), .look_valid(dmem_look_valid),
        .look_sec(d_look_sec_nc), .look_tag(d_look_tag_nc),
        .look_blk_sec(d_look_bsec_nc)
    );

    logic unused_misc;
    assign unused_misc = ^{d_sec, d_tag, d_look_sec_nc, d_look_tag_nc, d_look_bsec_nc,
                           imem_look_addr[1:0], imem_look_addr[15:IIW+2],
                           dmem_look_addr[1:0], dmem_look_addr[15:DIW+2]};

    // ---------------- registered read path ----------------
    logic [31:0] rd_next;

    always_comb begin
        rd_next = '0;
        if (hit_i) begin
            unique case (ikind)
                REG_CTRL: rd_next = {3'b000, i_sec[ip_idx], 3'b000, i_ainc[ip_idx],
                                     8'h00, i_offs[ip_idx]};
                REG_DATA: rd_next = i_acc_data;
                REG_TAG:  rd_next = {16'h0000, i_tag[ip_idx]};
                default:  rd_next = '0;
            endcase
        end else if (hit_d) begin
            unique case (dkind)
                REG_CTRL: rd_next = {7'b0000000, d_ainc[dp_idx], 8'h00, d_offs[dp_idx]};
                REG_DATA: rd_next = d_acc_data;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

    AST_ONE_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({i_data_wr, d_data_wr})); // R1
    AST_READ_KEEPS_IOFFS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(i_offs)); // R5
    AST_READ_KEEPS_DOFFS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable(d_offs)); // R5
endmodule

// File: tb/test_tagged_mem_window.sv
`timescale 1ns/1ps
module test_tagged_mem_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] imem_look_addr = '0;
    logic [31:0] imem_look_data;
    logic        imem_look_valid, imem_look_secure, imem_look_blk_secure;
    logic [15:0] imem_look_tag;
    logic [15:0] dmem_look_addr = '0;
    logic [31:0] dmem_look_data;
    logic        dmem_look_valid;

    int total = 0;
    int fails = 0;
    bit done = 0;
    logic rd_pend = 1'b0;
    logic [31:0] exp_q[$];
    string       req_q[$];

    always #10 clk = ~clk;

    tagged_mem_window i_tagged_mem_window (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .imem_look_addr(imem_look_addr), .imem_look_data(imem_look_data),
        .imem_look_valid(imem_look_valid), .imem_look_secure(imem_look_secure),
        .imem_look_tag(imem_look_tag), .imem_look_blk_secure(imem_look_blk_secure),
        .dmem_look_addr(dmem_look_addr), .dmem_look_data(dmem_look_data),
        .dmem_look_valid(dmem_look_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // driver: pushes the expected read value, monitor compares it
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        exp_q.push_back(exp);
        req_q.push_back(req);
        rd_pend = 1'b1;
        @(negedge clk);
        rd_pend = 1'b0;
    endtask

    always @(posedge clk) begin
        if (rd_pend) begin
            #1;
            chk(req_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
    end

    task automatic ilook(input logic [15:0] a, input logic [31:0] d, input logic v,
                         input logic s, input logic [15:0] t, input logic bs, input string req);
        imem_look_addr = a;
        #1;
        chk({req, " data"}, imem_look_data, d);
        chk({req, " valid"}, 32'(imem_look_valid), 32'(v));
        chk({req, " wsec"}, 32'(imem_look_secure), 32'(s));
        chk({req, " tag"}, 32'(imem_look_tag), 32'(t));
        chk({req, " bsec"}, 32'(imem_look_blk_secure), 32'(bs));
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    initial begin
        #4000000;
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R2 reset state, R8 nothing written
        rd(8'h00, 32'h0, "R2 reset ctrl");
        imem_look_addr = 16'h0; dmem_look_addr = 16'h0; #1;
        chk("R8 reset imem valid", 32'(imem_look_valid), 32'h0);
        chk("R8 reset dmem valid", 32'(dmem_look_valid), 32'h0);

        // instruction port 1: offset 0x103 -> 0x100, step, secure
        wr(8'h10, 32'h1100_0103);
        rd(8'h10, 32'h1100_0100, "R2 ictrl fields");
        wr(8'h18, 32'hFFFF_BEEF);
        rd(8'h18, 32'h0000_BEEF, "R6 tag readback");
        wr(8'h14, 32'hA000_0000);
        wr(8'h14, 32'hA000_0001);
        wr(8'h14, 32'hA000_0002);
        rd(8'h10, 32'h1100_010C, "R4 auto step");
        ilook(16'h0100, 32'hA000_0000, 1'b1, 1'b1, 16'hBEEF, 1'b1, "R3 R7 R8 first word");
        ilook(16'h0108, 32'hA000_0002, 1'b1, 1'b1, 16'hBEEF, 1'b1, "R3 third word");

        // instruction port 0: fixed offset 0x104, non-secure, tag 0x1234
        wr(8'h00, 32'h0000_0104);
        wr(8'h08, 32'h0000_1234);
        wr(8'h04, 32'hB000_0000);
        rd(8'h00, 32'h0000_0104, "R4 no step");
        ilook(16'h0104, 32'hB000_0000, 1'b1, 1'b0, 16'h1234, 1'b0, "R7 R8 latest writer");
        rd(8'h10, 32'h1100_010C, "R9 port1 untouched");
        rd(8'h04, 32'hB000_0000, "R5 data read");
        rd(8'h00, 32'h0000_0104, "R5 offset kept");

        // data port 5 at 0x68: bit 28 not kept
        wr(8'h68, 32'h1100_0020);
        rd(8'h68, 32'h0100_0020, "R2 dctrl no secure");
        wr(8'h6C, 32'hD000_0000);
        wr(8'h6C, 32'hD000_0001);
        rd(8'h68, 32'h0100_0028, "R4 dmem step");
        dmem_look_addr = 16'h0020; #1;
        chk("R3 dmem word0", dmem_look_data, 32'hD000_0000);
        chk("R8 dmem valid", 32'(dmem_look_valid), 32'h1);
        dmem_look_addr = 16'h0024; #1;
        chk("R3 dmem word1", dmem_look_data, 32'hD000_0001);
        rd(8'h40, 32'h0, "R9 dport0 untouched");
        wr(8'h40, 32'h0000_0024);
        rd(8'h44, 32'hD000_0001, "R5 R9 shared dmem read");

        // offset wrap and depth aliasing on instruction port 3
        wr(8'h38, 32'h0000_0077);
        wr(8'h30, 32'h0100_FFFF);
        wr(8'h34, 32'hC000_0000);
        rd(8'h30, 32'h0100_0000, "R4 16-bit wrap");
        ilook(16'h03FC, 32'hC000_0000, 1'b1, 1'b0, 16'h0077, 1'b0, "R3 R7 last block");
        ilook(16'h07FC, 32'hC000_0000, 1'b1, 1'b0, 16'h0077, 1'b0, "R3 alias");

        // R1 map: port 2 tag, other ports unaffected
        wr(8'h28, 32'h0000_0055);
        rd(8'h28, 32'h0000_0055, "R1 port2 tag");
        rd(8'h18, 32'h0000_BEEF, "R1 port1 tag kept");
        rd(8'h20, 32'h0, "R9 port2 ctrl");

        // R10 unmapped
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, 32'h0, "R10 hole read");
        rd(8'h00, 32'h0000_0104, "R10 hole write ignored");
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, 32'h0, "R10 beyond map");
        rd(8'h40, 32'h0000_0024, "R10 dmem ctrl kept");

        repeat (3) @(negedge clk);
        done = 1;
        summary();
    end
endmodule